// File: doc/BRIEF.md
# Saturating-Counter Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a direct-mapped table of small saturating counters, one per entry, and selects the entry from the low-order bits of the instruction address. The fetch stage presents a PC on the lookup port and receives a taken/not-taken guess in the same cycle. When a branch resolves later in the pipeline, its PC and real outcome go to the update port, and the chosen counter is trained. Both ports work in every cycle.

No tag is stored, so every lookup hits. Two branches whose low address bits agree share one counter and train it together. The counter width is a parameter. A width of one gives a last-outcome bit that is rewritten only when it was wrong. A width of two gives the usual hysteresis scheme, whose four states are named STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). For that width the transitions are named as follows: INC moves one state towards STRONG_T on a taken outcome, DEC moves one state towards STRONG_NT on a not-taken outcome, and HOLD keeps the state when the counter is already saturated in the outcome's direction. The one-bit width uses FLIP on a miss and HOLD on a hit.

Top module: `branch_dir_predictor`

## Requirements
- R1: The entry index is PC bits [IDX_W+1:2]. PC bits [1:0] and all bits above IDX_W+1 have no effect on which entry is used.
- R2: No tag is kept. PCs that differ only above bit IDX_W+1 read and train the same counter.
- R3: After reset every counter holds 2^(CTR_W-1)-1 (WEAK_NT for width 2, 0 for width 1), so every lookup predicts not taken.
- R4: lk_taken is 1 exactly when the counter selected by lk_pc is at least 2^(CTR_W-1). It follows lk_pc combinationally in the same cycle.
- R5: For CTR_W > 1, a valid update with up_taken=1 adds one to the counter, and one with up_taken=0 subtracts one.
- R6: Counters saturate. A taken update at 2^CTR_W-1 and a not-taken update at 0 leave the counter unchanged.
- R7: For CTR_W = 1, a valid update whose outcome differs from the stored bit inverts that bit. An update that agrees with the stored bit writes nothing.
- R8: A lookup and an update may occur in the same cycle. If both use the same entry, the lookup returns the value from before the update, and the new value is visible from the next cycle on.
- R9: A loop branch with the pattern nine taken then one not taken is mispredicted twice per pass at width 1 and once per pass at width 2 in steady state.
- R10: While up_valid is 0, up_pc and up_taken change no entry.
- R11: An update changes only the entry its own index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The same stimulus drives a width-2 and a width-1 instance side by side, so each pattern shows how hysteresis differs from last-outcome prediction. The repeated loop pattern separates the two miss rates. Runs of taken and not-taken updates past either end of the range separate saturation from wrap-around. Alias PCs and PCs that differ only in their low two bits test the index bit selection. A same-cycle lookup and update on one entry tests read-before-write, and updates held off by up_valid or aimed at a neighbouring entry test that unrelated entries stay untouched.

// File: rtl/bht_pkg.sv
package bht_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_DEC  = 2'd2,
        ACT_FLIP = 2'd3
    } ctr_act_e;
endpackage

// File: rtl/bht_idx.sv
module bht_idx #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // word-aligned instructions: skip the two byte-offset bits
    assign idx = pc[IDX_W+1:2];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[1:0], pc[PC_W-1:IDX_W+2]};
endmodule

// File: rtl/bht_ctr_next.sv
module bht_ctr_next
    import bht_pkg::*;
#(
    parameter int CTR_W = 2
) (
    input  logic [CTR_W-1:0] cur,
    input  logic             taken,
    output logic             we,
    output logic [CTR_W-1:0] nxt
);
    localparam logic [CTR_W-1:0] MAX = '1;

    ctr_act_e act;

    generate
        if (CTR_W == 1) begin : g_flip
            always_comb begin
                act = (cur[0] != taken) ? ACT_FLIP : ACT_HOLD;
            end
        end else begin : g_sat
            always_comb begin
                if (taken) act = (cur == MAX) ? ACT_HOLD : ACT_INC;
                else       act = (cur == '0)  ? ACT_HOLD : ACT_DEC;
            end
        end
    endgenerate

    always_comb begin
        unique case (act)
            ACT_HOLD: begin we = 1'b0; nxt = cur;               end
            ACT_INC:  begin we = 1'b1; nxt = cur + CTR_W'(1);   end
            ACT_DEC:  begin we = 1'b1; nxt = cur - CTR_W'(1);   end
            ACT_FLIP: begin we = 1'b1; nxt = ~cur;              end
            default:  begin we = 1'b0; nxt = cur;               end
        endcase
    end
endmodule

// File: rtl/bht_store.sv
module bht_store #(
    parameter int IDX_W = 12,
    parameter int CTR_W = 2,
    parameter logic [CTR_W-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [CTR_W-1:0] rd_a_ctr,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [CTR_W-1:0] rd_b_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CTR_W-1:0] wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CTR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_ctr;
        end
    end

    // reads see the array before this edge's write
    assign rd_a_ctr = mem[rd_a_idx];
    assign rd_b_ctr = mem[rd_b_idx];
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12,
    parameter int CTR_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam logic [CTR_W-1:0] HALF = CTR_W'(1) << (CTR_W - 1);
    localparam logic [CTR_W-1:0] INIT = HALF - CTR_W'(1);

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [CTR_W-1:0] lk_ctr, up_cur, up_nxt;
    logic             ctr_we, wr_en;

    bht_idx #(.PC_W(PC_W), .IDX_W(IDX_W)) lk_idx_i (.pc(lk_pc), .idx(lk_idx));
    bht_idx #(.PC_W(PC_W), .IDX_W(IDX_W)) up_idx_i (.pc(up_pc), .idx(up_idx));

    bht_store #(.IDX_W(IDX_W), .CTR_W(CTR_W), .INIT(INIT)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (lk_idx),
        .rd_a_ctr (lk_ctr),
        .rd_b_idx (up_idx),
        .rd_b_ctr (up_cur),
        .wr_en    (wr_en),
        .wr_idx   (up_idx),
        .wr_ctr   (up_nxt)
    );

    bht_ctr_next #(.CTR_W(CTR_W)) next_i (
        .cur   (up_cur),
        .taken (up_taken),
        .we    (ctr_we),
        .nxt   (up_nxt)
    );

    assign wr_en    = up_valid & ctr_we;
    assign lk_taken = (lk_ctr >= HALF);
endmodule

// File: rtl/bht_chk.sv
module bht_chk #(
    parameter int IDX_W = 12,
    parameter int CTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_valid,
    input logic             up_taken,
    input logic [IDX_W-1:0] up_idx,
    input logic [CTR_W-1:0] up_cur,
    input logic [CTR_W-1:0] up_nxt,
    input logic             wr_en,
    input logic [IDX_W-1:0] lk_idx,
    input logic [CTR_W-1:0] lk_ctr
);
    localparam logic [CTR_W-1:0] MAX = '1;

    // R6
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_cur == MAX) |-> !wr_en);

    // R6
    sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_cur == '0) |-> !wr_en);

    generate
        if (CTR_W > 1) begin : g_sat
            // R5
            step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |-> (up_taken ? (up_nxt == up_cur + CTR_W'(1))
                                    : (up_nxt == up_cur - CTR_W'(1))));
        end else begin : g_one
            // R7
            one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |-> (wr_en == (up_cur[0] != up_taken)));
        end
    endgenerate

    // R8
    wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && lk_idx == $past(up_idx))
            |-> lk_ctr == $past(up_nxt));

    // R11
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && lk_idx == $past(lk_idx))
            |-> lk_ctr == $past(lk_ctr));
endmodule

bind branch_dir_predictor bht_chk #(.IDX_W(IDX_W), .CTR_W(CTR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .up_idx   (up_idx),
    .up_cur   (up_cur),
    .up_nxt   (up_nxt),
    .wr_en    (wr_en),
    .lk_idx   (lk_idx),
    .lk_ctr   (lk_ctr)
);

// File: tb/branch_dir_predictor_tb_top.sv
`timescale 1ns/1ps
module branch_dir_predictor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [31:0] up_pc = '0;
    logic        up_valid = 1'b0;
    logic        up_taken = 1'b0;
    logic        lk_t2, lk_t1;

    always #2 clk = ~clk;

    branch_dir_predictor #(.PC_W(32), .IDX_W(12), .CTR_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_t2),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    branch_dir_predictor #(.PC_W(32), .IDX_W(12), .CTR_W(1)) dut_b1_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_t1),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    typedef struct {
        bit    one_bit;
        bit    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    m2 [4096];
    int    m1 [4096];
    bit    last_p2, last_p1;
    bit    done = 1'b0;

    function automatic int ix(input logic [31:0] pc);
        return int'((pc >> 2) & 32'hfff);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // driver: one cycle of stimulus, expectations pushed to the scoreboard
    task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                        input bit ut, input string tag, input bit chk);
        item_t it;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #1;
        if (chk) begin
            it.one_bit = 1'b0; it.exp = (m2[ix(lpc)] >= 2); it.tag = {tag, " w2"};
            q.push_back(it);
            it.one_bit = 1'b1; it.exp = (m1[ix(lpc)] == 1); it.tag = {tag, " w1"};
            q.push_back(it);
        end
        last_p2 = lk_t2;
        last_p1 = lk_t1;
        if (uv) begin
            if (ut) m2[ix(upc)] = (m2[ix(upc)] == 3) ? 3 : m2[ix(upc)] + 1;
            else    m2[ix(upc)] = (m2[ix(upc)] == 0) ? 0 : m2[ix(upc)] - 1;
            m1[ix(upc)] = ut ? 1 : 0;
        end
    endtask

    // monitor: compares each expected item against the output it names
    initial begin
        forever begin
            item_t it;
            wait (q.size() != 0);
            it = q.pop_front();
            check(it.tag, it.one_bit ? int'(lk_t1) : int'(lk_t2), int'(it.exp));
        end
    end

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] loop_pc, a_pc, c_pc, d_pc, e_pc, f_pc;
        int miss2, miss1;
        for (int i = 0; i < 4096; i++) begin m2[i] = 1; m1[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 R4: every entry starts weakly not taken
        step(32'h0000_0000, 0, 0, 0, "R3 R4 reset", 1);
        step(32'h0000_3ffc, 0, 0, 0, "R3 R4 reset", 1);
        step(32'h1234_5678, 0, 0, 0, "R3 R4 reset", 1);

        // R5: one taken update lifts WEAK_NT to WEAK_T
        step(0, 1, 32'h0000_0200, 1, "", 0);
        step(32'h0000_0200, 0, 0, 0, "R5 inc", 1);

        // R9: loop branch 9 taken then 1 not taken, lookup and resolve together
        loop_pc = 32'h0000_1040;
        miss2 = 0; miss1 = 0;
        for (int it = 0; it < 6; it++) begin
            for (int k = 0; k < 10; k++) begin
                step(loop_pc, 1, loop_pc, (k < 9), "R9 loop", 1);
                if (it >= 2) begin
                    if (last_p2 != (k < 9)) miss2++;
                    if (last_p1 != (k < 9)) miss1++;
                end
            end
        end
        check("R9 misses w2 over 4 passes", miss2, 4);
        check("R9 misses w1 over 4 passes", miss1, 8);

        // R2 R1: alias and byte-offset bits
        a_pc = 32'h0000_2008;
        step(0, 1, a_pc, 1, "", 0);
        step(0, 1, a_pc, 1, "", 0);
        step(a_pc + 32'h0000_4000, 0, 0, 0, "R2 alias", 1);
        step(a_pc + 32'h8000_0000, 0, 0, 0, "R2 alias", 1);
        step(a_pc + 32'h0000_0003, 0, 0, 0, "R1 low bits", 1);

        // R6 R7: saturation at top, then at floor
        c_pc = 32'h0000_0100;
        repeat (4) step(0, 1, c_pc, 1, "", 0);
        step(0, 1, c_pc, 0, "", 0);
        step(c_pc, 0, 0, 0, "R6 R7 top", 1);
        step(0, 1, c_pc, 0, "", 0);
        step(c_pc, 0, 0, 0, "R6 R7 down", 1);
        repeat (3) step(0, 1, c_pc, 0, "", 0);
        step(0, 1, c_pc, 1, "", 0);
        step(c_pc, 0, 0, 0, "R6 R7 floor", 1);
        step(0, 1, c_pc, 1, "", 0);
        step(c_pc, 0, 0, 0, "R6 R7 floor up", 1);

        // R8: same-cycle lookup and update on one entry
        d_pc = 32'h0000_0a00;
        step(d_pc, 1, d_pc, 1, "R8 old value", 1);
        step(d_pc, 0, 0, 0, "R8 new value", 1);

        // R10: updates without up_valid are dropped
        e_pc = 32'h0000_0c00;
        repeat (3) step(0, 0, e_pc, 1, "", 0);
        step(e_pc, 0, 0, 0, "R10 no valid", 1);

        // R11: neighbour entry untouched
        f_pc = 32'h0000_0e00;
        step(0, 1, f_pc, 1, "", 0);
        step(0, 1, f_pc, 1, "", 0);
        step(f_pc + 32'h4, 0, 0, 0, "R11 neighbour", 1);
        step(f_pc - 32'h4, 0, 0, 0, "R11 neighbour", 1);

        @(negedge clk);
        wait (q.size() == 0);
        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule